// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and walks the memory from power-up to normal operation. After reset it keeps the clock-enable line low and the chip deselected, so the device outputs stay in high impedance. It then waits for a power-stable indication and counts out a long, parameterised power-up delay. After that it raises clock enable with a NOP and issues a fixed command sequence on the command bus:

- precharge of all banks
- extended mode load that enables the DLL
- main mode load with the DLL-reset bit set
- a second precharge of all banks
- two auto refreshes
- a final main mode load with the DLL-reset bit cleared

Between commands it drives NOPs. Each gap is counted by a timer loaded from a timing parameter: precharge period, mode-load period or refresh cycle time. A separate counter starts at the DLL-reset mode load and enforces a lockout of DLL_LOCK cycles, 200 by default, before any read may follow. The ready flag rises only when the last mode-load gap and the DLL lockout have both elapsed. From then on the block holds clock enable high and idles the bus with NOPs, so the normal command scheduler can take over.

The mode payloads are built from three configuration inputs, whose values the block places into fixed address bits: burst-length code, burst-order select and read-latency code. All outputs come from flops.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and after reset until pwr_ok is sampled high, cke is 0, cs_n is 1 (deselect) and init_done is 0.
- R2: cke rises exactly PWRUP_CYC+1 clock edges after the first edge that samples pwr_ok high. In the first cycle with cke high, the bus carries NOP ({cs_n,ras_n,cas_n,we_n} = 0111). No command with cs_n low appears while cke is low, and cke stays high afterwards.
- R3: After the opening NOP, the non-NOP commands appear in exactly this order: PRE, LMR, LMR, PRE, REF, REF, LMR. The encodings are PRE = 0010, REF = 0001 and LMR = 0000 on {cs_n,ras_n,cas_n,we_n}.
- R4: Both precharges address all banks: addr[10] is 1.
- R5: The first mode load targets the extended register (ba = 2'b01) with addr all zero, so addr[0] = 0 enables the DLL.
- R6: The second and last mode loads target the main register (ba = 2'b00). Their payload is addr[2:0] = cfg_burst_len, addr[3] = cfg_interleave and addr[6:4] = cfg_latency. addr[8] is 1 in the first main load (DLL reset) and 0 in the last, and all other address bits are 0.
- R7: The spacing in cycles from each command to the next is 1 after the opening NOP, T_RP after each precharge, T_MRD after each mode load and T_RFC after each refresh. Every cycle in between carries NOP.
- R8: init_done first rises in the cycle max(M1 + DLL_LOCK, M2 + T_MRD), where M1 is the cycle of the DLL-reset mode load and M2 is the cycle of the last mode load. init_done then stays high, with cke high and only NOP on the bus.
- R9: Asserting rst_n low at any point of the sequence returns cke to 0, cs_n to 1 and init_done to 0 at once. The block stays idle until pwr_ok is seen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supplies and clock are stable |
| cfg_burst_len | input | 3 | Burst-length code placed in addr[2:0] of main mode loads |
| cfg_interleave | input | 1 | Burst-order select placed in addr[3] |
| cfg_latency | input | 3 | Read-latency code placed in addr[6:4] |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Row/mode address |
| init_done | output | 1 | Device initialised and ready for normal traffic |

## Verification
The bench times the power-up delay edge by edge. A design with an off-by-one in the delay counter or in the registered clock-enable path raises cke a cycle early or late and misses the exact edge count. It logs every non-NOP command with its cycle and checks each gap against its own timing parameter. A timer that reloads with the full value instead of value minus one, or that uses the wrong parameter for refresh, shows up as a stretched or mixed-up gap. It checks the DLL-reset and run-mode payloads bit by bit under two configurations, which exposes swapped fields or a DLL-reset bit left set. It also checks that ready waits for the 200-cycle lockout rather than only the last mode-load gap, and that a reset in mid-sequence drops clock enable at once.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // Command encodings on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_DESEL = 4'b1111,
        CMD_NOP   = 4'b0111,
        CMD_PRE   = 4'b0010,
        CMD_REF   = 4'b0001,
        CMD_LMR   = 4'b0000
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR,
        ST_RUN,
        ST_FINAL,
        ST_READY
    } state_e;

    // Selects which payload goes onto ba/addr in a given cycle
    typedef enum logic [2:0] {
        MS_NONE,
        MS_PREALL,
        MS_EXT,
        MS_MAIN_RST,
        MS_MAIN_RUN
    } msel_e;

    localparam int STEP_W = 3;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ddr_init_cnt.sv
module ddr_init_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count_o,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign zero_o  = (cnt_q == '0);

    // An expired counter never wraps back to a large value on its own
    AST_CNT_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load) |=> zero_o);  // R7

endmodule

// File: rtl/ddr_init_modeword.sv
module ddr_init_modeword
    import ddr_init_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2
) (
    input  msel_e              sel,
    input  logic [2:0]         burst_len,
    input  logic               interleave,
    input  logic [2:0]         latency,
    output logic [BANK_W-1:0]  ba_o,
    output logic [ROW_W-1:0]   addr_o
);

    localparam int BIT_ALLBANK = 10;
    localparam int BIT_DLLRST  = 8;

    always_comb begin
        ba_o   = '0;
        addr_o = '0;
        unique case (sel)
            MS_PREALL: begin
                addr_o[BIT_ALLBANK] = 1'b1;
            end
            MS_EXT: begin
                ba_o = BANK_W'(1);          // extended register, DLL enable (addr[0]=0)
            end
            MS_MAIN_RST: begin
                addr_o[2:0]        = burst_len;
                addr_o[3]          = interleave;
                addr_o[6:4]        = latency;
                addr_o[BIT_DLLRST] = 1'b1;
            end
            MS_MAIN_RUN: begin
                addr_o[2:0] = burst_len;
                addr_o[3]   = interleave;
                addr_o[6:4] = latency;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int BANK_W    = 2,
    parameter int PWRUP_CYC = 26600,
    parameter int T_RP      = 3,
    parameter int T_MRD     = 2,
    parameter int T_RFC     = 10,
    parameter int DLL_LOCK  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_interleave,
    input  logic [2:0]        cfg_latency,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic              init_done
);

    localparam int MAX_GAP = max4(PWRUP_CYC, T_RP, T_MRD, T_RFC);
    localparam int TMR_W   = $clog2(MAX_GAP + 1);
    localparam int DLL_W   = $clog2(DLL_LOCK + 1);

    typedef struct packed {
        state_e             state;
        logic [STEP_W-1:0]  step;
        cmd_e               cmd;
        logic               cke;
        logic [BANK_W-1:0]  ba;
        logic [ROW_W-1:0]   addr;
        logic               done;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state: ST_IDLE, step: '0, cmd: CMD_DESEL, cke: 1'b0,
        ba: '0, addr: '0, done: 1'b0
    };

    seq_t               seq_d, seq_q;
    msel_e              msel;
    logic               tmr_load, tmr_zero, dll_load, dll_zero;
    logic [TMR_W-1:0]   tmr_val, tmr_cnt;
    logic [DLL_W-1:0]   dll_cnt;
    logic [BANK_W-1:0]  mode_ba;
    logic [ROW_W-1:0]   mode_addr;

    ddr_init_cnt #(.W(TMR_W)) gap_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count_o  (tmr_cnt),
        .zero_o   (tmr_zero)
    );

    ddr_init_cnt #(.W(DLL_W)) dll_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dll_load),
        .load_val (DLL_W'(DLL_LOCK - 1)),
        .count_o  (dll_cnt),
        .zero_o   (dll_zero)
    );

    ddr_init_modeword #(.ROW_W(ROW_W), .BANK_W(BANK_W)) mode_i (
        .sel        (msel),
        .burst_len  (cfg_burst_len),
        .interleave (cfg_interleave),
        .latency    (cfg_latency),
        .ba_o       (mode_ba),
        .addr_o     (mode_addr)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.cmd = seq_q.cke ? CMD_NOP : CMD_DESEL;
        msel     = MS_NONE;
        tmr_load = 1'b0;
        tmr_val  = '0;
        dll_load = 1'b0;

        unique case (seq_q.state)
            ST_IDLE: begin
                if (pwr_ok) begin
                    seq_d.state = ST_PWR;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(PWRUP_CYC - 1);
                end
            end
            ST_PWR: begin
                if (tmr_zero) begin
                    seq_d.state = ST_RUN;
                    seq_d.step  = '0;
                end
            end
            ST_RUN: begin
                if (tmr_zero) begin
                    seq_d.step = seq_q.step + STEP_W'(1);
                    tmr_load   = 1'b1;
                    unique case (seq_q.step)
                        3'd0: begin
                            seq_d.cke = 1'b1;
                            seq_d.cmd = CMD_NOP;
                            tmr_val   = '0;
                        end
                        3'd1, 3'd4: begin
                            seq_d.cmd = CMD_PRE;
                            msel      = MS_PREALL;
                            tmr_val   = TMR_W'(T_RP - 1);
                        end
                        3'd2: begin
                            seq_d.cmd = CMD_LMR;
                            msel      = MS_EXT;
                            tmr_val   = TMR_W'(T_MRD - 1);
                        end
                        3'd3: begin
                            seq_d.cmd = CMD_LMR;
                            msel      = MS_MAIN_RST;
                            tmr_val   = TMR_W'(T_MRD - 1);
                            dll_load  = 1'b1;
                        end
                        3'd5, 3'd6: begin
                            seq_d.cmd = CMD_REF;
                            tmr_val   = TMR_W'(T_RFC - 1);
                        end
                        default: begin
                            seq_d.cmd   = CMD_LMR;
                            msel        = MS_MAIN_RUN;
                            tmr_val     = TMR_W'(T_MRD - 1);
                            seq_d.state = ST_FINAL;
                        end
                    endcase
                end
            end
            ST_FINAL: begin
                if (tmr_zero && dll_zero) begin
                    seq_d.state = ST_READY;
                    seq_d.done  = 1'b1;
                end
            end
            default: ;
        endcase

        seq_d.ba   = mode_ba;
        seq_d.addr = mode_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign cke                       = seq_q.cke;
    assign {cs_n, ras_n, cas_n, we_n} = seq_q.cmd;
    assign ba                        = seq_q.ba;
    assign addr                      = seq_q.addr;
    assign init_done                 = seq_q.done;

    logic unused_cnt;
    assign unused_cnt = ^{tmr_cnt, dll_cnt};

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> cs_n);  // R1

    AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);  // R2

    AST_PRE_ALLBANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && cas_n && !we_n) |-> addr[10]);  // R4

    AST_LMR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n) |-> (addr[ROW_W-1:9] == '0));  // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);  // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cke && !cs_n && ras_n && cas_n && we_n));  // R8

    AST_DONE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> dll_zero);  // R8

endmodule

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PW   = 64;
    localparam int TRP  = 3;
    localparam int TMRD = 2;
    localparam int TRFC = 9;
    localparam int DLL  = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_ok = 1'b0;
    logic [2:0]  cfg_burst_len = 3'd0;
    logic        cfg_interleave = 1'b0;
    logic [2:0]  cfg_latency = 3'd0;
    logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0]  ba;
    logic [12:0] addr;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_init_seq #(
        .ROW_W(13), .BANK_W(2), .PWRUP_CYC(PW), .T_RP(TRP),
        .T_MRD(TMRD), .T_RFC(TRFC), .DLL_LOCK(DLL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
        .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
        .cfg_latency(cfg_latency),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // R1: outputs while reset is held
    task automatic t_reset_state();
        rst_n  = 1'b0;
        pwr_ok = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(cke == 1'b0, "R1", "cke in reset", int'(cke), 0);
        chk(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
        chk(init_done == 1'b0, "R1", "init_done in reset", int'(init_done), 0);
    endtask

    // R1: nothing happens without pwr_ok
    task automatic t_hold_unpowered();
        int bad;
        bad = 0;
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            if (cke || !cs_n || init_done) bad++;
        end
        chk(bad == 0, "R1", "active cycles without pwr_ok", bad, 0);
    endtask

    // R2..R8: one full sequence with a given mode configuration
    task automatic t_full_init(input logic [2:0] bl, input logic bt, input logic [2:0] cl);
        int edges, cke_cyc, done_cyc, ncmd, early, late_bad, nop_at_cke, exp_done;
        logic [3:0]  kinds [8];
        int          when  [8];
        logic [12:0] ad    [8];
        logic [1:0]  bk    [8];
        logic [3:0]  exp_k [7];
        logic [12:0] exp_m;
        edges = 0; cke_cyc = -1; done_cyc = -1; ncmd = 0; early = 0; late_bad = 0;
        nop_at_cke = 0;
        exp_k = '{4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
        for (int i = 0; i < 8; i++) begin
            kinds[i] = '0; when[i] = 0; ad[i] = '0; bk[i] = '0;
        end

        @(negedge clk);
        rst_n = 1'b0;
        pwr_ok = 1'b0;
        cfg_burst_len = bl; cfg_interleave = bt; cfg_latency = cl;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) pwr_ok = 1'b1;

        for (;;) begin
            @(posedge clk); #1;
            edges++;
            if (!cke && !cs_n) early++;
            if (cke && cke_cyc < 0) begin
                cke_cyc = edges;
                nop_at_cke = ({cs_n, ras_n, cas_n, we_n} == 4'b0111) ? 1 : 0;
            end else if (cke_cyc >= 0 && {cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                if (ncmd < 8) begin
                    kinds[ncmd] = {cs_n, ras_n, cas_n, we_n};
                    when[ncmd]  = edges;
                    ad[ncmd]    = addr;
                    bk[ncmd]    = ba;
                end
                ncmd++;
                if (done_cyc >= 0) late_bad++;
            end
            if (init_done && done_cyc < 0) done_cyc = edges;
            if (done_cyc >= 0 && (!init_done || !cke)) late_bad++;
            if (done_cyc >= 0 && edges >= done_cyc + 20) break;
            if (edges > 2000) break;
        end

        // R2: edge 1 is the first edge that samples pwr_ok
        chk(cke_cyc == PW + 2, "R2", "cke rise edge", cke_cyc, PW + 2);
        chk(nop_at_cke == 1, "R2", "NOP with cke rise", nop_at_cke, 1);
        chk(early == 0, "R2", "commands while cke low", early, 0);
        // R3
        chk(ncmd == 7, "R3", "command count", ncmd, 7);
        for (int i = 0; i < 7; i++)
            chk(kinds[i] == exp_k[i], "R3", $sformatf("command %0d", i),
                int'(kinds[i]), int'(exp_k[i]));
        // R4
        chk(ad[0][10] == 1'b1, "R4", "first precharge A10", int'(ad[0][10]), 1);
        chk(ad[3][10] == 1'b1, "R4", "second precharge A10", int'(ad[3][10]), 1);
        // R5
        chk(bk[1] == 2'b01, "R5", "extended load bank", int'(bk[1]), 1);
        chk(ad[1] == '0, "R5", "extended load payload", int'(ad[1]), 0);
        // R6
        exp_m = {4'b0000, 1'b1, 1'b0, cl, bt, bl};
        chk(bk[2] == 2'b00, "R6", "DLL-reset load bank", int'(bk[2]), 0);
        chk(ad[2] == exp_m, "R6", "DLL-reset load payload", int'(ad[2]), int'(exp_m));
        exp_m[8] = 1'b0;
        chk(bk[6] == 2'b00, "R6", "run load bank", int'(bk[6]), 0);
        chk(ad[6] == exp_m, "R6", "run load payload", int'(ad[6]), int'(exp_m));
        // R7
        chk(when[0] - cke_cyc == 1, "R7", "NOP to precharge", when[0] - cke_cyc, 1);
        chk(when[1] - when[0] == TRP,  "R7", "precharge gap", when[1] - when[0], TRP);
        chk(when[2] - when[1] == TMRD, "R7", "ext load gap", when[2] - when[1], TMRD);
        chk(when[3] - when[2] == TMRD, "R7", "reset load gap", when[3] - when[2], TMRD);
        chk(when[4] - when[3] == TRP,  "R7", "second precharge gap", when[4] - when[3], TRP);
        chk(when[5] - when[4] == TRFC, "R7", "first refresh gap", when[5] - when[4], TRFC);
        chk(when[6] - when[5] == TRFC, "R7", "second refresh gap", when[6] - when[5], TRFC);
        // R8
        exp_done = (when[2] + DLL > when[6] + TMRD) ? when[2] + DLL : when[6] + TMRD;
        chk(done_cyc == exp_done, "R8", "ready cycle", done_cyc, exp_done);
        chk(late_bad == 0, "R8", "disturbances after ready", late_bad, 0);
    endtask

    // R9: reset in the middle of the sequence
    task automatic t_midway_reset();
        int bad;
        bad = 0;
        @(negedge clk);
        rst_n = 1'b0; pwr_ok = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) pwr_ok = 1'b1;
        repeat (PW + 20) @(posedge clk);
        #1;
        chk(cke == 1'b1, "R9", "cke up before abort", int'(cke), 1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(cke == 1'b0, "R9", "cke after abort", int'(cke), 0);
        chk(cs_n == 1'b1, "R9", "cs_n after abort", int'(cs_n), 1);
        chk(init_done == 1'b0, "R9", "init_done after abort", int'(init_done), 0);
        pwr_ok = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1;
            if (cke || !cs_n || init_done) bad++;
        end
        chk(bad == 0, "R9", "activity after abort without pwr_ok", bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog expired: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset_state();
        t_hold_unpowered();
        t_full_init(3'd3, 1'b0, 3'd6);   // burst 8, sequential, latency 2.5
        t_full_init(3'd2, 1'b1, 3'd2);   // burst 4, interleaved, latency 2
        t_midway_reset();
        finish_run();
    end

endmodule